// File: doc/BRIEF.md
# PWM Carrier Timer with Interrupt Culling

This block is the carrier timer behind a motor-control PWM stage. A triangular counter climbs from zero to a period value, then falls back to zero, and repeats. The period is held in active compare slot 3. Each arrival at the top is a peak event, and each return to zero is a zero-point event. A selectable prescaler divides the base clock to produce the count clock.

One culling counter is shared by both kinds of event. It lets only every Nth event through to the two interrupt pulse outputs. Four buffer registers can be written at any time. Their contents move into the four active compare registers only at chosen event boundaries, so a new duty set never lands in the middle of a carrier period.

A new prescaler code or culling ratio written while the timer runs does not take effect at once. It waits for a particular interrupt boundary. Writes made while the timer is stopped take effect immediately. All inputs are plain register-write strobes and level controls. No data stream crosses the block edge, so no port has a valid/ready handshake.

Top module: `pwmc_timer`

## Requirements
- R1: After reset the four active compare outputs read 0, both interrupt pulses are low, the divide code is 000 and the culling code is 000.
- R2: While `run_en` is high, count ticks come every D base cycles, and each event takes P ticks, where P is active compare 3 and D is the divide ratio. Event k (k = 1, 2, ...) happens at base edge k·P·D, counting edges from the first one that sees `run_en` high. Odd-numbered events are peaks and even-numbered events are zero points. An event that passes culling shows its pulse in the cycle right after that edge.
- R3: Each interrupt pulse lasts exactly one cycle, and `irq_zero` and `irq_peak` are never high together.
- R4: Culling codes 000, 001, 010, 011 and 100 select 1/1, 1/2, 1/4, 1/8 and 1/16. One counter counts events of both kinds, and only every Nth event produces a pulse. A write of code 101, 110 or 111 is ignored.
- R5: Divide codes 000 to 101 select divide-by 1, 2, 4, 8, 16 and 32. A write of code 110 or 111 is ignored, and the previous divider stays.
- R6: A divide code written while running takes effect only at a zero-point event that passes culling, and the next tick then comes after the new D cycles. A zero-point event that is culled does not switch the divider. A write made while stopped takes effect at once.
- R7: A culling code written while running takes effect only after one more pulse has been produced at the old ratio. Counting under the new ratio starts from that pulse. A write made while stopped takes effect at once.
- R8: When both `xfer_en_a` and `xfer_en_b` are high, all four buffers are copied into the active compare registers at every event that passes culling. At a culled event the copy happens only if `xfer_cull_ovr` is 1. With either enable low, no copy happens.
- R9: While `run_en` is high, writes to the active compare registers are ignored. While it is low, such a write shows on the output in the following cycle. Buffer writes are accepted in either state.
- R10: When `run_en` is low, the counter, prescaler and culling counters are held cleared and no pulse is produced. The next start therefore repeats the timing of R2 exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Count enable; low stops and clears the counters |
| clksel_we | input | 1 | Write strobe for the divide code |
| clksel_wdata | input | 3 | Divide code |
| cull_we | input | 1 | Write strobe for the culling code |
| cull_wdata | input | 3 | Culling code |
| xfer_en_a | input | 1 | First buffer-transfer enable |
| xfer_en_b | input | 1 | Second buffer-transfer enable |
| xfer_cull_ovr | input | 1 | Allow transfers at culled events |
| buf_we | input | 1 | Buffer register write strobe |
| buf_sel | input | 2 | Buffer register index |
| buf_wdata | input | 16 | Buffer register data |
| cmp_we | input | 1 | Active compare write strobe (only acts when stopped) |
| cmp_sel | input | 2 | Active compare index |
| cmp_wdata | input | 16 | Active compare data |
| cmp0 | output | 16 | Active compare 0 |
| cmp1 | output | 16 | Active compare 1 |
| cmp2 | output | 16 | Active compare 2 |
| cmp3 | output | 16 | Active compare 3 (carrier period) |
| irq_zero | output | 1 | Zero-point interrupt pulse |
| irq_peak | output | 1 | Peak interrupt pulse |

## Verification
If the count, prescaler or culling state inside the block goes wrong, the fault first appears as an interrupt pulse at the wrong base cycle, of the wrong kind, or missing altogether. This shows up no later than the next P·D-cycle event after the fault. A pending divide or culling change that is applied at the wrong boundary moves every later pulse, so a single mistimed apply makes the whole following pulse train wrong. A wrong transfer decision shows on the compare outputs on the edge of the event itself. For that reason the compare values are sampled one cycle before and in the cycle of chosen culled and non-culled events.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;
  localparam int CNT_W        = 16;
  localparam int NCMP         = 4;
  localparam int CODE_W       = 3;
  localparam int DIV_CODE_MAX = 5;
  localparam int CUL_CODE_MAX = 4;
  localparam int PRE_W        = DIV_CODE_MAX;
  localparam int CUL_W        = CUL_CODE_MAX;
endpackage

// File: rtl/pwmc_defer_reg.sv
module pwmc_defer_reg #(
  parameter int W     = 3,
  parameter int LIMIT = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic         apply,
  output logic [W-1:0] act
);
  logic [W-1:0] pend;
  logic         pend_v;
  logic         legal;

  assign legal = (int'(wdata) <= LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act    <= '0;
      pend   <= '0;
      pend_v <= 1'b0;
    end else if (!run) begin
      if (pend_v) begin
        act    <= pend;
        pend_v <= 1'b0;
      end
      if (we && legal) begin
        act    <= wdata;
        pend_v <= 1'b0;
      end
    end else begin
      if (apply && pend_v) begin
        act    <= pend;
        pend_v <= 1'b0;
      end
      if (we && legal) begin
        pend   <= wdata;
        pend_v <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwmc_prescaler.sv
module pwmc_prescaler #(
  parameter int CODE_W = 3,
  parameter int PRE_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] lim;

  assign lim  = PRE_W'((32'd1 << code) - 32'd1);
  assign tick = run && (pre_cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_cnt <= '0;
    else if (!run)   pre_cnt <= '0;
    else if (tick)   pre_cnt <= '0;
    else             pre_cnt <= pre_cnt + PRE_W'(1);
  end
endmodule

// File: rtl/pwmc_carrier.sv
module pwmc_carrier #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] period,
  output logic         zero_ev,
  output logic         peak_ev
);
  logic [W-1:0] cnt;
  logic         up;
  logic [W:0]   nxt_up;

  assign nxt_up  = {1'b0, cnt} + (W+1)'(1);
  assign peak_ev = tick && up && (nxt_up >= {1'b0, period});
  assign zero_ev = tick && !up && (cnt <= W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      up  <= 1'b1;
    end else if (!run) begin
      cnt <= '0;
      up  <= 1'b1;
    end else if (tick) begin
      if (up) begin
        if (peak_ev) begin
          cnt <= period;
          up  <= 1'b0;
        end else begin
          cnt <= nxt_up[W-1:0];
        end
      end else if (zero_ev) begin
        cnt <= '0;
        up  <= 1'b1;
      end else begin
        cnt <= cnt - W'(1);
      end
    end
  end
endmodule

// File: rtl/pwmc_cull.sv
module pwmc_cull #(
  parameter int CODE_W = 3,
  parameter int CUL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              ev,
  input  logic [CODE_W-1:0] code,
  output logic              pass
);
  logic [CUL_W-1:0] cnt;
  logic [CUL_W-1:0] lim;

  assign lim  = CUL_W'((32'd1 << code) - 32'd1);
  assign pass = ev && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (!run)  cnt <= '0;
    else if (ev)    cnt <= pass ? '0 : cnt + CUL_W'(1);
  end
endmodule

// File: rtl/pwmc_cmpbank.sv
module pwmc_cmpbank #(
  parameter int W  = 16,
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                buf_we,
  input  logic [IW-1:0]       buf_sel,
  input  logic [W-1:0]        buf_wdata,
  input  logic                act_we,
  input  logic [IW-1:0]       act_sel,
  input  logic [W-1:0]        act_wdata,
  input  logic                xfer,
  output logic [N-1:0][W-1:0] act
);
  logic [N-1:0][W-1:0] shadow;

  for (genvar i = 0; i < N; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow[i] <= '0;
        act[i]    <= '0;
      end else begin
        if (buf_we && buf_sel == IW'(i))
          shadow[i] <= buf_wdata;
        if (xfer)
          act[i] <= shadow[i];
        else if (act_we && !run && act_sel == IW'(i))
          act[i] <= act_wdata;
      end
    end
  end
endmodule

// File: rtl/pwmc_timer.sv
module pwmc_timer
  import pwmc_pkg::*;
#(
  parameter int W      = CNT_W,
  parameter int CW     = CODE_W,
  parameter int DIVMAX = DIV_CODE_MAX,
  parameter int CULMAX = CUL_CODE_MAX
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic          clksel_we,
  input  logic [CW-1:0] clksel_wdata,
  input  logic          cull_we,
  input  logic [CW-1:0] cull_wdata,
  input  logic          xfer_en_a,
  input  logic          xfer_en_b,
  input  logic          xfer_cull_ovr,
  input  logic          buf_we,
  input  logic [1:0]    buf_sel,
  input  logic [W-1:0]  buf_wdata,
  input  logic          cmp_we,
  input  logic [1:0]    cmp_sel,
  input  logic [W-1:0]  cmp_wdata,
  output logic [W-1:0]  cmp0,
  output logic [W-1:0]  cmp1,
  output logic [W-1:0]  cmp2,
  output logic [W-1:0]  cmp3,
  output logic          irq_zero,
  output logic          irq_peak
);
  localparam int IW   = $clog2(NCMP);
  localparam int PW   = DIVMAX;
  localparam int CULW = CULMAX;

  logic [CW-1:0]         div_code, cul_code;
  logic                  tick, zero_ev, peak_ev, any_ev, pass, xfer_fire;
  logic [NCMP-1:0][W-1:0] act;

  assign any_ev    = zero_ev || peak_ev;
  assign xfer_fire = any_ev && xfer_en_a && xfer_en_b && (pass || xfer_cull_ovr);

  pwmc_defer_reg #(.W(CW), .LIMIT(DIVMAX)) u_div_sel (
    .clk, .rst_n, .run(run_en), .we(clksel_we), .wdata(clksel_wdata),
    .apply(zero_ev && pass), .act(div_code));

  pwmc_defer_reg #(.W(CW), .LIMIT(CULMAX)) u_cul_sel (
    .clk, .rst_n, .run(run_en), .we(cull_we), .wdata(cull_wdata),
    .apply(pass), .act(cul_code));

  pwmc_prescaler #(.CODE_W(CW), .PRE_W(PW)) u_pre (
    .clk, .rst_n, .run(run_en), .code(div_code), .tick);

  pwmc_carrier #(.W(W)) u_car (
    .clk, .rst_n, .run(run_en), .tick, .period(act[NCMP-1]),
    .zero_ev, .peak_ev);

  pwmc_cull #(.CODE_W(CW), .CUL_W(CULW)) u_cul (
    .clk, .rst_n, .run(run_en), .ev(any_ev), .code(cul_code), .pass);

  pwmc_cmpbank #(.W(W), .N(NCMP), .IW(IW)) u_bank (
    .clk, .rst_n, .run(run_en),
    .buf_we, .buf_sel, .buf_wdata,
    .act_we(cmp_we), .act_sel(cmp_sel), .act_wdata(cmp_wdata),
    .xfer(xfer_fire), .act);

  assign cmp0 = act[0];
  assign cmp1 = act[1];
  assign cmp2 = act[2];
  assign cmp3 = act[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_zero <= 1'b0;
      irq_peak <= 1'b0;
    end else begin
      irq_zero <= zero_ev && pass;
      irq_peak <= peak_ev && pass;
    end
  end
endmodule

// File: rtl/pwmc_timer_chk.sv
module pwmc_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run_en,
  input logic         xfer_en_a,
  input logic         xfer_en_b,
  input logic         xfer_fire,
  input logic [W-1:0] cmp0,
  input logic [W-1:0] cmp1,
  input logic [W-1:0] cmp2,
  input logic [W-1:0] cmp3,
  input logic         irq_zero,
  input logic         irq_peak
);
  a_r3_zero_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_zero |=> !irq_zero);

  a_r3_peak_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_peak |=> !irq_peak);

  a_r3_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_zero && irq_peak));

  a_r10_quiet_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !(irq_zero || irq_peak));

  a_r9_active_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !xfer_fire) |=>
      ($stable(cmp0) && $stable(cmp1) && $stable(cmp2) && $stable(cmp3)));

  a_r8_both_enables: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !(xfer_en_a && xfer_en_b)) |=>
      ($stable(cmp0) && $stable(cmp1) && $stable(cmp2) && $stable(cmp3)));
endmodule

bind pwmc_timer pwmc_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en),
  .xfer_en_a(xfer_en_a), .xfer_en_b(xfer_en_b), .xfer_fire(xfer_fire),
  .cmp0(cmp0), .cmp1(cmp1), .cmp2(cmp2), .cmp3(cmp3),
  .irq_zero(irq_zero), .irq_peak(irq_peak));

// File: tb/tb_pwmc_timer.sv
module tb_pwmc_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic        clksel_we = 1'b0;
  logic [2:0]  clksel_wdata = '0;
  logic        cull_we = 1'b0;
  logic [2:0]  cull_wdata = '0;
  logic        xfer_en_a = 1'b0, xfer_en_b = 1'b0, xfer_cull_ovr = 1'b0;
  logic        buf_we = 1'b0;
  logic [1:0]  buf_sel = '0;
  logic [15:0] buf_wdata = '0;
  logic        cmp_we = 1'b0;
  logic [1:0]  cmp_sel = '0;
  logic [15:0] cmp_wdata = '0;
  logic [15:0] cmp0, cmp1, cmp2, cmp3;
  logic        irq_zero, irq_peak;

  int n_chk = 0, n_err = 0, cyc = 0, c0 = 0;
  int exp_kind[$];
  int exp_cyc[$];
  string cur_req = "R2";

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwmc_timer dut (
    .clk, .rst_n, .run_en, .clksel_we, .clksel_wdata, .cull_we, .cull_wdata,
    .xfer_en_a, .xfer_en_b, .xfer_cull_ovr, .buf_we, .buf_sel, .buf_wdata,
    .cmp_we, .cmp_sel, .cmp_wdata, .cmp0, .cmp1, .cmp2, .cmp3,
    .irq_zero, .irq_peak);

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: pop expected pulses and compare kind (1=peak, 0=zero) and cycle
  always @(negedge clk) begin : mon
    int k, ek, ec;
    if (rst_n && (irq_zero || irq_peak)) begin
      k = irq_peak ? 1 : 0;
      n_chk++;
      if (exp_kind.size() == 0) begin
        n_err++;
        $display("FAIL %s: pulse kind=%0d at cycle %0d, expected none", cur_req, k, cyc);
      end else begin
        ek = exp_kind.pop_front();
        ec = exp_cyc.pop_front();
        if (ek != k || ec != cyc) begin
          n_err++;
          $display("FAIL %s: pulse kind=%0d cycle=%0d, expected kind=%0d cycle=%0d",
                   cur_req, k, cyc, ek, ec);
        end
      end
    end
  end

  // driver-side model of the expected pulse train from R2, R4, R6, R7
  task automatic plan(int p, int d0, int n0, int d1, int n1,
                      bit dpend, bit npend, int nev);
    int edge_n = 0, cc = 0, d = d0, n = n0;
    bit peak = 1'b1;
    for (int i = 0; i < nev; i++) begin
      edge_n += p * d;
      cc++;
      if (cc == n) begin
        cc = 0;
        exp_kind.push_back(peak ? 1 : 0);
        exp_cyc.push_back(c0 + edge_n);
        if (npend) begin n = n1; npend = 1'b0; end
        if (!peak && dpend) begin d = d1; dpend = 1'b0; end
      end
      peak = !peak;
    end
  endtask

  task automatic chk_empty(string req);
    chk(req, exp_kind.size(), 0);
    exp_kind.delete();
    exp_cyc.delete();
  endtask

  task automatic to_cyc(int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic wr_cmp(int s, int v);
    cmp_we = 1'b1; cmp_sel = 2'(s); cmp_wdata = 16'(v);
    @(negedge clk); cmp_we = 1'b0;
  endtask

  task automatic wr_buf(int s, int v);
    buf_we = 1'b1; buf_sel = 2'(s); buf_wdata = 16'(v);
    @(negedge clk); buf_we = 1'b0;
  endtask

  task automatic wr_div(int c);
    clksel_we = 1'b1; clksel_wdata = 3'(c);
    @(negedge clk); clksel_we = 1'b0;
  endtask

  task automatic wr_cul(int c);
    cull_we = 1'b1; cull_wdata = 3'(c);
    @(negedge clk); cull_we = 1'b0;
  endtask

  task automatic start();
    run_en = 1'b1; c0 = cyc;
  endtask

  task automatic stop();
    run_en = 1'b0; @(negedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", cmp0, 0); chk("R1", cmp3, 0);
    chk("R1", {30'd0, irq_zero, irq_peak}, 0);

    // R9 active writes while stopped
    wr_cmp(3, 5); wr_cmp(0, 'h11); wr_cmp(1, 'h22); wr_cmp(2, 'h33);
    chk("R9", cmp3, 5); chk("R9", cmp0, 'h11);

    // R2/R3 basic triangle, divide 1, cull 1/1
    cur_req = "R2";
    start(); plan(5, 1, 1, 1, 1, 0, 0, 6);
    to_cyc(c0 + 7); wr_cmp(0, 'hAA);
    to_cyc(c0 + 9); chk("R9", cmp0, 'h11);
    to_cyc(c0 + 32); stop(); chk_empty("R2");

    // R4/R5 legal and illegal codes: divide 2, cull 1/4
    cur_req = "R4/R5";
    wr_div(1); wr_div(6); wr_cul(2); wr_cul(7);
    start(); plan(5, 2, 4, 2, 4, 0, 0, 8);
    to_cyc(c0 + 85); stop(); chk_empty("R4/R5");

    // R10 stop mid-way then restart from clean state
    cur_req = "R10";
    start(); to_cyc(c0 + 25); stop(); chk_empty("R10");
    start(); plan(5, 2, 4, 2, 4, 0, 0, 4);
    to_cyc(c0 + 45); stop(); chk_empty("R10");

    // R6 deferred divider: culled zero at edge 8 keeps D, passed zero at 16 switches
    cur_req = "R6";
    wr_div(0); wr_cul(2); wr_cmp(3, 4);
    start(); plan(4, 1, 4, 4, 4, 1, 0, 8);
    to_cyc(c0 + 2); wr_div(2);
    to_cyc(c0 + 85); stop(); chk_empty("R6");

    // R7 deferred culling ratio: one more pulse at 1/1, then 1/2
    cur_req = "R7";
    wr_div(0); wr_cul(0);
    start(); plan(4, 1, 1, 1, 2, 0, 1, 6);
    to_cyc(c0 + 1); wr_cul(1);
    to_cyc(c0 + 26); stop(); chk_empty("R7");

    // R8 transfer gating: cull 1/2, period 8
    cur_req = "R8";
    wr_cul(1); wr_cmp(3, 8);
    xfer_en_a = 1'b1;
    wr_buf(0, 'h100); wr_buf(1, 'h200); wr_buf(2, 'h300); wr_buf(3, 8);
    start(); plan(8, 1, 2, 1, 2, 0, 0, 4);
    to_cyc(c0 + 18); chk("R8", cmp0, 'h11);
    xfer_en_b = 1'b1;
    to_cyc(c0 + 25); chk("R8", cmp0, 'h11);
    to_cyc(c0 + 31); chk("R8", cmp1, 'h22);
    to_cyc(c0 + 32);
    chk("R8", cmp0, 'h100); chk("R8", cmp1, 'h200);
    chk("R8", cmp2, 'h300); chk("R8", cmp3, 8);
    to_cyc(c0 + 34); stop(); chk_empty("R8");

    // R8 override at culled event, R9 buffer write while running
    xfer_cull_ovr = 1'b1; wr_buf(0, 'h555);
    start(); plan(8, 1, 2, 1, 2, 0, 0, 2);
    to_cyc(c0 + 7); chk("R8", cmp0, 'h100);
    to_cyc(c0 + 8); chk("R8", cmp0, 'h555);
    to_cyc(c0 + 9); wr_buf(1, 'h777);
    to_cyc(c0 + 16); chk("R9", cmp1, 'h777);
    to_cyc(c0 + 18); stop(); chk_empty("R8");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule